// File: doc/BRIEF.md
# Background and Sprite Pixel Priority Mux

Each dot, this block takes the 4-bit background pixel code and the 4-bit sprite pixel code from the two pixel pipelines. It merges them into the 5-bit palette RAM index for that dot. Each layer first passes a gate that drops it when the layer is turned off, or when left-edge clipping is on for that layer and the dot lies in the leftmost eight columns. A resolver then picks one layer from the sprite's front-priority tag and from the transparency of the two codes. Finally it folds transparent indices onto the shared backdrop entries.

The same stage detects a collision between an opaque sprite-zero pixel and an opaque background pixel. It keeps that event in a sticky flag, which is cleared at the start of the pre-render line. When both layers are off, a visible dot shows the palette entry that the VRAM address selects, if that address lies in the palette window. Otherwise the dot shows entry 0. Outside the visible area the index is 0. Both outputs are registered, so the result for the inputs of one clock appears after that clock edge.

The hit tracker is a two-state machine. `HIT_CLEAR` moves to `HIT_SEEN` on the transition `COLLIDE`. `HIT_SEEN` moves back to `HIT_CLEAR` on the transition `FRAME_RESTART`, which fires on dot 0 of the pre-render line. In every other case the state holds. Reset puts the machine in `HIT_CLEAR`.

Top module: `pix_prio_mux`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pal_idx` is 0 and `hit_flag` is 0.
- R2: On a visible dot with rendering on, if only the background is opaque the index is `{1'b0, bg_code}`. If only the sprite is opaque the index is `{1'b1, spr_code}`. A code is opaque when its low two bits are not 00.
- R3: A layer contributes code 0, with its tags cleared, when its enable is low, or when its clip input is high and `dot` < 8.
- R4: When both gated codes are opaque, the sprite wins if `spr_front` is 1. Otherwise the background wins.
- R5: A transparent background code always yields the sprite index. Otherwise a transparent sprite code always yields the background index. These rules override `spr_front`.
- R6: Whenever the chosen index has low bits 00 it is ANDed with 0x0C, so bit 4 is 0 and transparent sprite entries alias background entries.
- R7: `hit_flag` rises one cycle after a dot on a visible line with rendering on where both gated codes are opaque, the gated sprite carries `spr_zero`, and `dot` < 255. It then stays high.
- R8: `hit_flag` is 0 in the cycle after a dot with `line` = 261 and `dot` = 0.
- R9: With `bg_en` and `spr_en` both low on a visible dot, if `vram_addr[13:8]` = 0x3F the index is `vram_addr[4:0]` under the R6 mask. Otherwise it is 0.
- R10: When `line` >= 240 or `dot` >= 256, `pal_idx` is 0.
- R11: `pal_idx` changes only at a clock edge and reflects the inputs present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| dot | input | 9 | Horizontal dot position of the current inputs |
| line | input | 9 | Scanline position of the current inputs |
| bg_en | input | 1 | Background layer enable |
| spr_en | input | 1 | Sprite layer enable |
| bg_clip | input | 1 | Hide background in the leftmost 8 dots |
| spr_clip | input | 1 | Hide sprites in the leftmost 8 dots |
| bg_code | input | 4 | Background pixel code (palette select in bits 3:2) |
| spr_code | input | 4 | Sprite pixel code (palette select in bits 3:2) |
| spr_front | input | 1 | Sprite is drawn in front of the background |
| spr_zero | input | 1 | Sprite pixel belongs to sprite zero |
| vram_addr | input | 14 | Current VRAM address, used when rendering is off |
| pal_idx | output | 5 | Registered palette RAM index |
| hit_flag | output | 1 | Sticky sprite-zero collision flag |

## Verification
A wrong layer decision or a wrong mirror mask shows up in `pal_idx` on the very next clock. The reference model compares every cycle, so a bad index is found at the dot that caused it. A wrong hit-tracker state is more persistent. A missed or spurious collision changes `hit_flag` one clock later and stays wrong until the next pre-render line. A missed restart leaves the flag high across the frame boundary. The stimulus therefore mixes clipped columns, the dot-255 edge, transparent codes and frame restarts.

// File: rtl/pix_prio_mux_pkg.sv
package pix_prio_mux_pkg;

    typedef enum logic {
        HIT_CLEAR = 1'b0,
        HIT_SEEN  = 1'b1
    } hit_state_e;

    // Transparent indices keep only the palette select bits.
    function automatic logic [4:0] mirror_mask(input logic [4:0] idx);
        return (idx[1:0] == 2'b00) ? (idx & 5'h0C) : idx;
    endfunction

endpackage

// File: rtl/pm_layer_gate.sv
module pm_layer_gate #(
    parameter int DOT_W     = 9,
    parameter int DATA_W    = 4,
    parameter int CLIP_DOTS = 8
) (
    input  logic              en,
    input  logic              clip,
    input  logic [DOT_W-1:0]  dot,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out
);
    localparam logic [DOT_W-1:0] CLIP_LIM = DOT_W'(CLIP_DOTS);

    logic hidden;

    always_comb begin
        hidden   = !en || (clip && (dot < CLIP_LIM));
        data_out = hidden ? '0 : data_in;
    end
endmodule

// File: rtl/pm_resolve.sv
module pm_resolve
    import pix_prio_mux_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] bg_code,
    input  logic [CODE_W-1:0] spr_code,
    input  logic              spr_front,
    output logic [CODE_W:0]   idx,
    output logic              both_opaque
);
    logic bg_opaque;
    logic spr_opaque;
    logic [CODE_W:0] pick;

    always_comb begin
        bg_opaque   = (bg_code[1:0] != 2'b00);
        spr_opaque  = (spr_code[1:0] != 2'b00);
        both_opaque = bg_opaque && spr_opaque;
        if (!bg_opaque)
            pick = {1'b1, spr_code};
        else if (!spr_opaque)
            pick = {1'b0, bg_code};
        else if (spr_front)
            pick = {1'b1, spr_code};
        else
            pick = {1'b0, bg_code};
        idx = mirror_mask(pick);
    end
endmodule

// File: rtl/pm_hit_fsm.sv
module pm_hit_fsm
    import pix_prio_mux_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic collide,
    input  logic restart,
    output logic hit
);
    hit_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= HIT_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIT_CLEAR: if (collide) state_d = HIT_SEEN;   // COLLIDE
            HIT_SEEN:  if (restart) state_d = HIT_CLEAR;  // FRAME_RESTART
            default:   state_d = HIT_CLEAR;
        endcase
    end

    assign hit = (state_q == HIT_SEEN);
endmodule

// File: rtl/pix_prio_mux.sv
module pix_prio_mux
    import pix_prio_mux_pkg::*;
#(
    parameter int DOT_W       = 9,
    parameter int LINE_W      = 9,
    parameter int CODE_W      = 4,
    parameter int VRAM_W      = 14,
    parameter int VIS_DOTS    = 256,
    parameter int VIS_LINES   = 240,
    parameter int CLIP_DOTS   = 8,
    parameter int HIT_DOT_END = 255,
    parameter int PRE_LINE    = 261
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              bg_en,
    input  logic              spr_en,
    input  logic              bg_clip,
    input  logic              spr_clip,
    input  logic [CODE_W-1:0] bg_code,
    input  logic [CODE_W-1:0] spr_code,
    input  logic              spr_front,
    input  logic              spr_zero,
    input  logic [VRAM_W-1:0] vram_addr,
    output logic [CODE_W:0]   pal_idx,
    output logic              hit_flag
);
    localparam int SPR_W = CODE_W + 2;
    localparam logic [DOT_W-1:0]  DOT_LIM  = DOT_W'(VIS_DOTS);
    localparam logic [DOT_W-1:0]  HIT_LIM  = DOT_W'(HIT_DOT_END);
    localparam logic [LINE_W-1:0] LINE_LIM = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] PRE_LN   = LINE_W'(PRE_LINE);

    logic [CODE_W-1:0] bg_g;
    logic [SPR_W-1:0]  spr_g;
    logic [CODE_W:0]   mixed_idx;
    logic [CODE_W:0]   forced_idx;
    logic [CODE_W:0]   idx_d;
    logic              both_opaque;
    logic              visible;
    logic              render_on;
    logic              collide;
    logic              restart;
    logic              unused_vram;

    pm_layer_gate #(.DOT_W(DOT_W), .DATA_W(CODE_W), .CLIP_DOTS(CLIP_DOTS)) u_bg_gate (
        .en(bg_en), .clip(bg_clip), .dot(dot),
        .data_in(bg_code), .data_out(bg_g)
    );

    pm_layer_gate #(.DOT_W(DOT_W), .DATA_W(SPR_W), .CLIP_DOTS(CLIP_DOTS)) u_spr_gate (
        .en(spr_en), .clip(spr_clip), .dot(dot),
        .data_in({spr_zero, spr_front, spr_code}), .data_out(spr_g)
    );

    pm_resolve #(.CODE_W(CODE_W)) u_resolve (
        .bg_code(bg_g), .spr_code(spr_g[CODE_W-1:0]), .spr_front(spr_g[CODE_W]),
        .idx(mixed_idx), .both_opaque(both_opaque)
    );

    assign unused_vram = ^vram_addr[7:5];

    always_comb begin
        visible   = (line < LINE_LIM) && (dot < DOT_LIM);
        render_on = bg_en || spr_en;
        collide   = visible && render_on && both_opaque && spr_g[CODE_W+1] && (dot < HIT_LIM);
        restart   = (line == PRE_LN) && (dot == '0);

        if (vram_addr[VRAM_W-1:8] == '1)
            forced_idx = mirror_mask(vram_addr[4:0]);
        else
            forced_idx = '0;

        if (!visible)
            idx_d = '0;
        else if (render_on)
            idx_d = mixed_idx;
        else
            idx_d = forced_idx;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pal_idx <= '0;
        else
            pal_idx <= idx_d;
    end

    pm_hit_fsm u_hit (
        .clk(clk), .rst(rst), .collide(collide), .restart(restart), .hit(hit_flag)
    );
endmodule

// File: rtl/pix_prio_mux_chk.sv
module pix_prio_mux_chk #(
    parameter int DOT_W  = 9,
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [DOT_W-1:0]  dot,
    input logic [LINE_W-1:0] line,
    input logic              bg_en,
    input logic              spr_en,
    input logic [4:0]        pal_idx,
    input logic              hit_flag
);
    assert_reset_R1: assert property (@(posedge clk) rst |=> (pal_idx == 5'd0 && !hit_flag));

    assert_offscreen_R10: assert property (@(posedge clk) disable iff (rst)
        (line >= 9'd240 || dot >= 9'd256) |=> (pal_idx == 5'd0));

    assert_mirror_R6: assert property (@(posedge clk) disable iff (rst)
        (pal_idx[1:0] == 2'b00) |-> (pal_idx[4] == 1'b0));

    assert_hit_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (hit_flag && !(line == 9'd261 && dot == 9'd0)) |=> hit_flag);

    assert_hit_window_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hit_flag) |-> ($past(dot) < 9'd255 && $past(line) < 9'd240
                             && ($past(bg_en) || $past(spr_en))));

    assert_hit_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (line == 9'd261 && dot == 9'd0) |=> !hit_flag);
endmodule

bind pix_prio_mux pix_prio_mux_chk #(.DOT_W(DOT_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .dot(dot), .line(line), .bg_en(bg_en), .spr_en(spr_en),
    .pal_idx(pal_idx), .hit_flag(hit_flag)
);

// File: tb/pix_prio_mux_test.sv
module pix_prio_mux_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [8:0] dot = '0, line = '0;
    logic bg_en = 0, spr_en = 0, bg_clip = 0, spr_clip = 0, spr_front = 0, spr_zero = 0;
    logic [3:0] bg_code = '0, spr_code = '0;
    logic [13:0] vram_addr = '0;
    logic [4:0] pal_idx;
    logic hit_flag;

    int n_tests = 0;
    int n_fail = 0;
    int e_hit = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_prio_mux uut (
        .clk(clk), .rst(rst), .dot(dot), .line(line), .bg_en(bg_en), .spr_en(spr_en),
        .bg_clip(bg_clip), .spr_clip(spr_clip), .bg_code(bg_code), .spr_code(spr_code),
        .spr_front(spr_front), .spr_zero(spr_zero), .vram_addr(vram_addr),
        .pal_idx(pal_idx), .hit_flag(hit_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fold(input int v);
        return ((v % 4) == 0) ? (v & 12) : v;
    endfunction

    // Behavioural reference: returns index, updates expected hit, names the rule used.
    function automatic int model(output string req);
        int b, s, fr, zt, res;
        bit vis, ron, bop, sop;
        vis = (int'(line) < 240) && (int'(dot) < 256);
        ron = bg_en || spr_en;
        b = (bg_en && !(bg_clip && dot < 8)) ? int'(bg_code) : 0;
        if (spr_en && !(spr_clip && dot < 8)) begin
            s = int'(spr_code); fr = int'(spr_front); zt = int'(spr_zero);
        end else begin
            s = 0; fr = 0; zt = 0;
        end
        bop = (b % 4) != 0;
        sop = (s % 4) != 0;
        if (line == 261 && dot == 0) e_hit = 0;
        else if (vis && ron && bop && sop && zt == 1 && dot < 255) e_hit = 1;
        if (!vis) begin req = "R10"; res = 0; end
        else if (!ron) begin
            req = "R9";
            res = (vram_addr[13:8] == 6'h3F) ? fold(int'(vram_addr[4:0])) : 0;
        end
        else if (!bop) begin req = "R5"; res = fold(16 + s); end
        else if (!sop) begin req = "R2"; res = b; end
        else begin req = "R4"; res = fr ? 16 + s : b; end
        return res;
    endfunction

    task automatic step(input string tag);
        string r;
        int e;
        e = model(r);
        @(posedge clk);
        #1;
        check({tag, " ", r}, int'(pal_idx), e);
        check({tag, " hit R7"}, int'(hit_flag), e_hit);
    endtask

    task automatic setv(input int ln, input int dt, input int be, input int se,
                        input int bc, input int sc, input int fr, input int zt);
        line = 9'(ln); dot = 9'(dt); bg_en = 1'(be); spr_en = 1'(se);
        bg_code = 4'(bc); spr_code = 4'(sc); spr_front = 1'(fr); spr_zero = 1'(zt);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 idx", int'(pal_idx), 0);
        check("R1 hit", int'(hit_flag), 0);
        rst = 0;

        setv(10, 20, 1, 0, 4'h6, 0, 0, 0); step("R2 bg only");
        setv(10, 21, 0, 1, 0, 4'hB, 0, 0); step("R2 spr only");
        setv(10, 22, 1, 1, 4'h5, 4'h7, 1, 0); step("R4 front");
        setv(10, 23, 1, 1, 4'h5, 4'h7, 0, 0); step("R4 behind");
        setv(10, 24, 1, 1, 4'h4, 4'h9, 0, 0); step("R5 bg clear");
        setv(10, 25, 1, 1, 4'h9, 4'hC, 1, 0); step("R5 spr clear");
        setv(10, 26, 1, 1, 4'h8, 4'hC, 1, 0); step("R6 both clear");
        bg_clip = 1; setv(10, 3, 1, 1, 4'h5, 4'h6, 0, 1); step("R3 bg clipped");
        check("R3 no hit", int'(hit_flag), 0);
        bg_clip = 0; spr_clip = 1; setv(10, 7, 1, 1, 4'h5, 4'h6, 1, 1); step("R3 spr clipped");
        spr_clip = 0;
        setv(10, 255, 1, 1, 4'h5, 4'h6, 1, 1); step("R7 dot255 no hit");
        check("R7 edge", int'(hit_flag), 0);
        setv(10, 254, 1, 1, 4'h5, 4'h6, 1, 1); step("R7 set");
        check("R7 set", int'(hit_flag), 1);
        setv(20, 30, 1, 1, 4'h1, 4'h0, 0, 0); step("R7 sticky");
        setv(261, 0, 1, 1, 0, 0, 0, 0); step("R8 restart");
        check("R8 cleared", int'(hit_flag), 0);
        vram_addr = 14'h3F13; setv(50, 40, 0, 0, 4'h5, 4'h5, 0, 0); step("R9 window");
        vram_addr = 14'h3F1C; step("R9 mirror");
        vram_addr = 14'h2F05; step("R9 outside");
        setv(240, 40, 1, 1, 4'h5, 4'h5, 0, 0); step("R10 line");
        setv(10, 300, 1, 1, 4'h5, 4'h5, 0, 0); step("R10 dot");
        setv(10, 60, 1, 0, 4'h7, 0, 0, 0);
        #2;
        check("R11 held before edge", int'(pal_idx), 0);
        step("R11 after edge");

        for (int i = 0; i < 4000; i++) begin
            int lsel;
            lsel = $urandom_range(0, 15);
            line = (lsel == 0) ? 9'd261 : (lsel == 1) ? 9'd240 : 9'($urandom_range(0, 239));
            dot = (lsel < 3 || $urandom_range(0, 7) == 0) ? 9'($urandom_range(0, 9))
                                                         : 9'($urandom_range(0, 340));
            bg_en = ($urandom_range(0, 5) != 0); spr_en = ($urandom_range(0, 5) != 0);
            bg_clip = 1'($urandom_range(0, 1)); spr_clip = 1'($urandom_range(0, 1));
            bg_code = 4'($urandom_range(0, 15)); spr_code = 4'($urandom_range(0, 15));
            spr_front = 1'($urandom_range(0, 1)); spr_zero = ($urandom_range(0, 9) == 0);
            vram_addr = ($urandom_range(0, 1) == 1) ? 14'(16'h3F00 | $urandom_range(0, 255))
                                                    : 14'($urandom_range(0, 16383));
            step("random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule